// File: doc/BRIEF.md
# Halfband Decimate-by-Two Filter (Polyphase)

This block halves the sample rate of one signed 16-bit stream. It uses a 7-tap halfband low-pass filter built in polyphase form, so it computes only the outputs that decimation keeps. Even-indexed samples feed a 4-tap leg with taps 0, 2, 4 and 6. Odd-indexed samples feed a second leg. Because a halfband filter has a single nonzero odd tap (the centre tap, index 3), that second leg is only a two-sample delay followed by one multiply. The sum of the two legs is rescaled from Q15, saturated and sent out as one 16-bit sample.

Two input arrangements are supported. In single-lane mode (`mode_ext` low), one sample arrives per accepted beat on `in_a`, and the block sorts samples into even and odd by an internal phase. A `sync` pulse forces the next accepted sample onto the even leg. In paired mode (`mode_ext` high), every beat carries an even sample on `in_a` and the odd sample that follows it in time on `in_b`, and `sync` is ignored. Coefficients sit in registers and are written one tap at a time.

Both data sides use valid/ready. An input beat is accepted on a clock edge where `in_valid` and `in_ready` are both high. An output beat is consumed on an edge where `out_valid` and `out_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A stalled output holds `out_valid` and `out_data` steady. Because the pipeline freezes during a stall, no sample and no result is dropped.

Top module: `hb_decim2`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. All coefficient registers and both delay lines are zero, so the first outputs before any coefficient write are 0.
- R2: Number the even samples E[j] and the odd samples O[j] (O[j] is the sample right after E[j]). When E[j] is accepted, the block produces one output, y = E[j-3]·C0 + E[j-2]·C2 + E[j-1]·C4 + E[j]·C6 + O[j-2]·C3. History from before reset counts as zero. `out_data` is y shifted arithmetically right by 15 bits, with saturation.
- R3: In single-lane mode, the first sample accepted after reset is even, and accepted samples then alternate even, odd, even. Exactly one output is produced per even sample, and none per odd sample.
- R4: In single-lane mode, a `sync` high in some cycle makes the first sample accepted in a later cycle even. A sample accepted in the same cycle as `sync` keeps its current phase.
- R5: In paired mode, each accepted beat pushes `in_a` as E[j] and `in_b` as O[j] and produces exactly one output. `sync` has no effect.
- R6: A write with `coef_we` high sets the tap chosen by `coef_sel`: tap indices 0, 2, 3, 4 and 6 are writable, and writes to indices 1, 5 and 7 are ignored. A new value applies only to samples accepted after the write edge.
- R7: Results above 32767 are sent out as 32767, and results below -32768 as -32768.
- R8: `in_ready` equals (not `out_valid`) or `out_ready`. A stalled output keeps `out_valid` and `out_data` stable. Outputs leave in the order of their even samples, and none is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_ext | input | 1 | 1: paired even/odd input beats; 0: single-lane input |
| sync | input | 1 | Single-lane phase alignment pulse |
| coef_we | input | 1 | Coefficient write enable |
| coef_sel | input | 3 | Tap index to write |
| coef_val | input | 16 | Signed Q15 coefficient value |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat can be taken |
| in_a | input | 16 | Signed sample (even sample in paired mode) |
| in_b | input | 16 | Signed odd sample, used in paired mode only |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream can take the output |
| out_data | output | 16 | Signed decimated sample |

## Verification
The hardest case to reach from the ports is a phase change that lands on a stall boundary. This means a `sync` pulse that falls in the same cycle as an accepted sample, or in a cycle where the input is held off because the output is blocked. In either case the even/odd assignment of later samples has to follow R4 exactly. The stimulus reaches these cases by pulsing `sync` at random points while `in_valid` and `out_ready` are also toggled at random. A behavioural model then predicts the outputs, built only from the sample numbering and tap equation of R2. Saturation is reached by loading full-scale coefficients and driving full-scale inputs of a single sign.

// File: rtl/hb_decim2_pkg.sv
package hb_decim2_pkg;
  typedef enum logic {PH_EVEN = 1'b0, PH_ODD = 1'b1} phase_t;
endpackage

// File: rtl/hb_coef_bank.sv
module hb_coef_bank #(
  parameter int TAPS = 7,
  parameter int CW   = 16,
  localparam int NE   = (TAPS + 1) / 2,
  localparam int CTR  = (TAPS - 1) / 2,
  localparam int SELW = $clog2(TAPS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [SELW-1:0]        sel,
  input  logic [CW-1:0]          val,
  output logic [NE-1:0][CW-1:0]  ev_coef,
  output logic [CW-1:0]          ctr_coef
);
  logic [CW-1:0] ev_q [NE];
  logic [CW-1:0] ctr_q;

  for (genvar g = 0; g < NE; g++) begin : g_even
    always_ff @(posedge clk) begin
      if (!rst_n)                             ev_q[g] <= '0;
      else if (we && sel == SELW'(2 * g))     ev_q[g] <= val;
    end
    assign ev_coef[g] = ev_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        ctr_q <= '0;
    else if (we && sel == SELW'(CTR))  ctr_q <= val;
  end
  assign ctr_coef = ctr_q;

  // R6: with no write strobe every tap keeps its value
  assert_coef_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(ev_coef) && $stable(ctr_coef));
endmodule

// File: rtl/hb_legs.sv
module hb_legs
  import hb_decim2_pkg::*;
#(
  parameter int TAPS = 7,
  parameter int DW   = 16,
  localparam int NE   = (TAPS + 1) / 2,
  localparam int ODLY = NE / 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   accept,
  input  logic                   mode_ext,
  input  logic                   sync,
  input  logic [DW-1:0]          a,
  input  logic [DW-1:0]          b,
  output logic                   trig,
  output logic [NE-1:0][DW-1:0]  ev_taps,
  output logic [DW-1:0]          odd_tap
);
  phase_t        ph_q;
  logic [DW-1:0] ev_q [NE-1];
  logic [DW-1:0] od_q [ODLY];
  logic          take_even, take_odd;

  assign take_even = mode_ext || (ph_q == PH_EVEN);
  assign take_odd  = mode_ext || (ph_q == PH_ODD);
  assign trig      = accept && take_even;

  always_ff @(posedge clk) begin
    if (!rst_n)                     ph_q <= PH_EVEN;
    else if (!mode_ext && sync)     ph_q <= PH_EVEN;
    else if (!mode_ext && accept)   ph_q <= (ph_q == PH_EVEN) ? PH_ODD : PH_EVEN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NE - 1; i++) ev_q[i] <= '0;
    end else if (accept && take_even) begin
      ev_q[0] <= a;
      for (int i = 1; i < NE - 1; i++) ev_q[i] <= ev_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ODLY; i++) od_q[i] <= '0;
    end else if (accept && take_odd) begin
      od_q[0] <= mode_ext ? b : a;
      for (int i = 1; i < ODLY; i++) od_q[i] <= od_q[i-1];
    end
  end

  for (genvar g = 0; g < NE; g++) begin : g_tap
    if (g == NE - 1) begin : g_new
      assign ev_taps[g] = a;
    end else begin : g_old
      assign ev_taps[g] = ev_q[NE-2-g];
    end
  end
  assign odd_tap = od_q[ODLY-1];

  // R5: in paired mode every accepted beat yields an output
  assert_pair_trig_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && mode_ext |-> trig);
  // R4: first sample accepted after a sync cycle lands on the even leg
  assert_sync_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_ext && $past(!mode_ext && sync) && accept |-> trig);
  // R3: an even sample in single-lane mode is followed by an odd one unless resynced
  assert_alternate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_ext && trig && !sync |=> !(accept && !mode_ext && !$past(sync) && take_even && trig && ph_q == PH_EVEN));
endmodule

// File: rtl/hb_mac.sv
module hb_mac #(
  parameter int TAPS = 7,
  parameter int DW   = 16,
  parameter int CW   = 16,
  localparam int NE   = (TAPS + 1) / 2,
  localparam int NP   = NE + 1,
  localparam int PW   = DW + CW,
  localparam int GW   = $clog2(NP),
  localparam int SW   = PW + GW,
  localparam int FRAC = CW - 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   adv,
  input  logic                   trig,
  input  logic [NE-1:0][DW-1:0]  ev_taps,
  input  logic [DW-1:0]          odd_tap,
  input  logic [NE-1:0][CW-1:0]  ev_coef,
  input  logic [CW-1:0]          ctr_coef,
  output logic                   out_valid,
  output logic [DW-1:0]          out_data
);
  localparam logic signed [SW-1:0] SAT_HI = (SW'(1) <<< (DW - 1)) - SW'(1);
  localparam logic signed [SW-1:0] SAT_LO = -(SW'(1) <<< (DW - 1));

  logic signed [PW-1:0] prod_q [NP];
  logic                 p_vld;
  logic signed [SW-1:0] sum, scaled;

  for (genvar g = 0; g < NE; g++) begin : g_even_mul
    always_ff @(posedge clk) begin
      if (!rst_n)            prod_q[g] <= '0;
      else if (adv && trig)  prod_q[g] <= $signed(ev_taps[g]) * $signed(ev_coef[g]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            prod_q[NE] <= '0;
    else if (adv && trig)  prod_q[NE] <= $signed(odd_tap) * $signed(ctr_coef);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    p_vld <= 1'b0;
    else if (adv)  p_vld <= trig;
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < NP; i++) sum = sum + SW'(prod_q[i]);
    scaled = sum >>> FRAC;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (adv) begin
      out_valid <= p_vld;
      if (p_vld) begin
        if (scaled > SAT_HI)       out_data <= SAT_HI[DW-1:0];
        else if (scaled < SAT_LO)  out_data <= SAT_LO[DW-1:0];
        else                       out_data <= scaled[DW-1:0];
      end
    end
  end

  // R8: a blocked output holds its beat unchanged
  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !adv |=> out_valid && $stable(out_data));
  // R7: positive overflow clamps to the top code
  assert_sat_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
    adv && p_vld && (scaled > SAT_HI) |=> out_data == SAT_HI[DW-1:0]);
  // R7: negative overflow clamps to the bottom code
  assert_sat_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
    adv && p_vld && (scaled < SAT_LO) |=> out_data == SAT_LO[DW-1:0]);
endmodule

// File: rtl/hb_decim2.sv
module hb_decim2 #(
  parameter int TAPS = 7,
  parameter int DW   = 16,
  parameter int CW   = 16,
  localparam int NE   = (TAPS + 1) / 2,
  localparam int SELW = $clog2(TAPS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_ext,
  input  logic            sync,
  input  logic            coef_we,
  input  logic [SELW-1:0] coef_sel,
  input  logic [CW-1:0]   coef_val,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [DW-1:0]   in_a,
  input  logic [DW-1:0]   in_b,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [DW-1:0]   out_data
);
  logic                  adv, accept, trig;
  logic [NE-1:0][CW-1:0] ev_coef;
  logic [CW-1:0]         ctr_coef;
  logic [NE-1:0][DW-1:0] ev_taps;
  logic [DW-1:0]         odd_tap;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;
  assign accept   = in_valid && adv;

  hb_coef_bank #(.TAPS(TAPS), .CW(CW)) i_coef (
    .clk(clk), .rst_n(rst_n), .we(coef_we), .sel(coef_sel), .val(coef_val),
    .ev_coef(ev_coef), .ctr_coef(ctr_coef)
  );

  hb_legs #(.TAPS(TAPS), .DW(DW)) i_legs (
    .clk(clk), .rst_n(rst_n), .accept(accept), .mode_ext(mode_ext), .sync(sync),
    .a(in_a), .b(in_b), .trig(trig), .ev_taps(ev_taps), .odd_tap(odd_tap)
  );

  hb_mac #(.TAPS(TAPS), .DW(DW), .CW(CW)) i_mac (
    .clk(clk), .rst_n(rst_n), .adv(adv), .trig(trig), .ev_taps(ev_taps),
    .odd_tap(odd_tap), .ev_coef(ev_coef), .ctr_coef(ctr_coef),
    .out_valid(out_valid), .out_data(out_data)
  );

  // R8: no input is taken while the output beat is blocked
  assert_no_take_when_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
endmodule

// File: tb/test_hb_decim2.sv
module test_hb_decim2;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_ext = 1'b0, sync = 1'b0, coef_we = 1'b0;
  logic [2:0]  coef_sel = '0;
  logic [15:0] coef_val = '0, in_a = '0, in_b = '0;
  logic        in_valid = 1'b0, out_ready = 1'b1;
  logic        in_ready, out_valid;
  logic [15:0] out_data;

  always #2 clk = ~clk;

  hb_decim2 i_hb_decim2 (
    .clk(clk), .rst_n(rst_n), .mode_ext(mode_ext), .sync(sync),
    .coef_we(coef_we), .coef_sel(coef_sel), .coef_val(coef_val),
    .in_valid(in_valid), .in_ready(in_ready), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  string cur_req = "R1";
  int c[7];
  int ev[3];
  int od[2];
  int ph = 0;
  int expq[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_out(input int e_new, input int o_old);
    longint y;
    y = longint'(ev[2]) * c[0] + longint'(ev[1]) * c[2] + longint'(ev[0]) * c[4]
      + longint'(e_new) * c[6] + longint'(o_old) * c[3];
    y = y >>> 15;
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    return int'(y);
  endfunction

  task automatic push_even(input int e);
    expq.push_back(ref_out(e, od[1]));
    ev[2] = ev[1]; ev[1] = ev[0]; ev[0] = e;
  endtask

  task automatic push_odd(input int o);
    od[1] = od[0]; od[0] = o;
  endtask

  // one clock: apply drive, compare before the edge, advance model
  task automatic cyc(input bit v, input int a, input int b, input bit rdy,
                     input bit syn, input bit we, input int sel, input int val);
    bit acc;
    int got, exp;
    @(negedge clk);
    in_valid = v; in_a = 16'(a); in_b = 16'(b); out_ready = rdy; sync = syn;
    coef_we = we; coef_sel = 3'(sel); coef_val = 16'(val);
    #1;
    check(in_ready == (!out_valid || out_ready), "R8", int'(in_ready), int'(!out_valid || out_ready));
    if (out_valid && out_ready) begin
      got = int'($signed(out_data));
      if (expq.size() == 0) check(1'b0, cur_req, got, 0);
      else begin
        exp = expq.pop_front();
        check(got == exp, cur_req, got, exp);
      end
    end
    acc = in_valid && in_ready;
    if (acc) begin
      if (mode_ext) begin
        push_even(int'($signed(in_a)));
        push_odd(int'($signed(in_b)));
      end else if (ph == 0) begin
        push_even(int'($signed(in_a)));
        ph = 1;
      end else begin
        push_odd(int'($signed(in_a)));
        ph = 0;
      end
    end
    if (syn && !mode_ext) ph = 0;
    if (we && (sel == 0 || sel == 2 || sel == 3 || sel == 4 || sel == 6)) c[sel] = val;
  endtask

  task automatic feed(input int n, input int vpct, input int rpct, input int spct, input int amp);
    for (int i = 0; i < n; i++) begin
      int a, b;
      a = ($urandom % (2 * amp + 1)) - amp;
      b = ($urandom % (2 * amp + 1)) - amp;
      cyc(($urandom % 100) < vpct, a, b, ($urandom % 100) < rpct,
          ($urandom % 100) < spct, 1'b0, 0, 0);
    end
  endtask

  task automatic wr(input int sel, input int val);
    cyc(1'b0, 0, 0, 1'b1, 1'b0, 1'b1, sel, val);
  endtask

  task automatic drain();
    for (int i = 0; i < 6; i++) cyc(1'b0, 0, 0, 1'b1, 1'b0, 1'b0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 7; i++) c[i] = 0;
    ev = '{0, 0, 0}; od = '{0, 0};
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    cur_req = "R1";
    check(out_valid == 1'b0, "R1", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1", int'(in_ready), 1);
    feed(12, 100, 100, 0, 20000);           // zero coefficients give zero outputs
    drain();

    cur_req = "R6";
    wr(0, -2048); wr(2, 9216); wr(3, 16384); wr(4, 9216); wr(6, -2048);
    wr(1, 30000); wr(5, -30000); wr(7, 12345);   // ignored taps
    cur_req = "R2";
    cyc(1'b1, 16384, 0, 1'b1, 1'b0, 1'b0, 0, 0);  // impulse on even leg
    for (int i = 0; i < 9; i++) cyc(1'b1, 0, 0, 1'b1, 1'b0, 1'b0, 0, 0);
    cyc(1'b1, 0, 0, 1'b1, 1'b0, 1'b0, 0, 0);
    cyc(1'b1, 16384, 0, 1'b1, 1'b0, 1'b0, 0, 0);  // impulse on odd leg
    for (int i = 0; i < 8; i++) cyc(1'b1, 0, 0, 1'b1, 1'b0, 1'b0, 0, 0);
    feed(80, 100, 100, 0, 32767);
    drain();

    cur_req = "R3";
    feed(120, 70, 100, 0, 30000);
    drain();

    cur_req = "R4";
    cyc(1'b1, 1000, 0, 1'b1, 1'b0, 1'b0, 0, 0);     // even
    cyc(1'b1, 2000, 0, 1'b1, 1'b1, 1'b0, 0, 0);     // odd, sync same cycle
    cyc(1'b1, 3000, 0, 1'b1, 1'b0, 1'b0, 0, 0);     // forced even
    cyc(1'b1, 4000, 0, 1'b1, 1'b1, 1'b0, 0, 0);     // odd, sync
    cyc(1'b0, 0, 0, 1'b1, 1'b1, 1'b0, 0, 0);        // sync, idle
    cyc(1'b1, 5000, 0, 1'b1, 1'b0, 1'b0, 0, 0);     // even
    feed(300, 80, 70, 15, 32767);
    drain();

    cur_req = "R8";
    feed(400, 90, 40, 5, 32767);
    drain();
    check(expq.size() == 0, "R8", expq.size(), 0);

    cur_req = "R5";
    mode_ext = 1'b1;
    feed(300, 80, 70, 30, 32767);
    drain();
    mode_ext = 1'b0;
    ph = 0;
    cyc(1'b0, 0, 0, 1'b1, 1'b1, 1'b0, 0, 0);        // realign after mode change

    cur_req = "R7";
    wr(0, 32767); wr(2, 32767); wr(3, 32767); wr(4, 32767); wr(6, 32767);
    for (int i = 0; i < 20; i++) cyc(1'b1, 32767, 0, 1'b1, 1'b0, 1'b0, 0, 0);
    for (int i = 0; i < 20; i++) cyc(1'b1, -32768, 0, 1'b1, 1'b0, 1'b0, 0, 0);
    feed(100, 100, 80, 0, 32767);
    drain();

    cur_req = "R6";
    for (int i = 0; i < 200; i++) begin
      int sel, val;
      sel = $urandom % 8;
      val = ($urandom % 65536) - 32768;
      cyc(($urandom % 100) < 85, ($urandom % 65536) - 32768, 0,
          ($urandom % 100) < 80, 1'b0, ($urandom % 100) < 20, sel, val);
    end
    drain();
    check(expq.size() == 0, "R6", expq.size(), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog requirement=%s actual=timeout expected=done", cur_req);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule